// File: doc/BRIEF.md
# Inter-Core Interrupt Unit

This block lets the cores of a small multicore cluster interrupt one another. Each core owns a command port with a valid strobe, a two-bit opcode and a core-index argument. Each port also has its own readback register. One command is taken per cycle. When several ports request in the same cycle, the lowest-numbered port wins, and the others hold their command until they are accepted.

Pending requests are kept in a square matrix of bits: row = sending core, column = receiving core. Each core has one interrupt output, and that output is the OR of its column. When several senders target the same core, their requests merge into a single asserted line. The target then asks which cores are behind the interrupt, and gets back a vector with one bit per sender. More than one bit can be set. The target must clear each sender separately before its line drops.

Top module: `icu_top`

## Requirements
- R1: While reset is asserted and after it is released, every interrupt output is low and every readback register reads zero.
- R2: Among the ports with valid high in a cycle, only the lowest-numbered one sees its accept output high. At most one accept is high per cycle, and a port that is not accepted keeps waiting.
- R3: An accepted raise command (opcode 0) from port i with argument t sets the pending bit from i to t. The output irq_out[t] is high from the cycle after acceptance.
- R4: irq_out[t] is high whenever any sender has a pending bit toward t. Raises from several senders toward one target drive a single line.
- R5: An accepted clear command (opcode 1) from port j with argument s clears only the pending bit from s toward j. A clear whose bit is not set changes no interrupt output and no other pending bit.
- R6: A target's interrupt output stays high until the bit of every sender toward it has been cleared.
- R7: An accepted status command (opcode 2) from port i with argument c loads port i's readback with bit 0 = pending bit from i to c, and all other bits zero.
- R8: An accepted source command (opcode 3) from port i loads port i's readback with bit n = pending bit from core n toward core i, for every n.
- R9: A port's readback changes only on the clock edge at which that port's command is accepted. It is valid from the next cycle and holds until that port's next accepted command. Accepted raise and clear commands load zero.
- R10: Raising an already pending bit leaves it a single bit: one clear removes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | N | Per-port command request |
| cmd_op | input | 2*N | Per-port opcode, port p at bits [2p+1:2p] |
| cmd_core | input | IW*N | Per-port core argument, port p at bits [IW*p+IW-1:IW*p] |
| cmd_accept | output | N | Per-port acceptance strobe for the current cycle |
| rd_data | output | N*N | Per-port readback, port p at bits [N*p+N-1:N*p] |
| irq_out | output | N | Interrupt line per target core |

## Verification
Two ports raise toward the same core in one cycle. This checks that the lower port is taken first and that the loser is taken next. A broken priority encoder would grant both ports or the wrong one. The merged line is then drained one sender at a time through the source vector. A design that cleared a whole column, or dropped the line on the first clear, would show it low too early. A clear aimed at a bit that is not set must leave another sender's pending request intact. A second raise of a bit that is already pending must not need two clears. The bench also checks that a port's readback keeps its old value while other ports change the matrix. A design that recomputed the readback combinationally would show the new state there.

// File: rtl/icu_pkg.sv
package icu_pkg;
    typedef enum logic [1:0] {
        OP_RAISE  = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_STATUS = 2'd2,
        OP_SOURCE = 2'd3
    } icu_op_e;
endpackage

// File: rtl/icu_arb.sv
module icu_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] win,
    output logic          any
);
    // fixed priority: lowest index wins, scan from the top so the last hit stays
    always_comb begin
        gnt = '0;
        win = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                win    = IW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/icu_pend.sv
module icu_pend
    import icu_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd,
    input  icu_op_e        op,
    input  logic [IW-1:0]  src,
    input  logic [IW-1:0]  arg,
    output logic [N*N-1:0] pend,
    output logic [N-1:0]   irq
);
    typedef struct packed {
        logic [N*N-1:0] bits;
    } pend_t;

    pend_t         st_d, st_q;
    logic [N-1:0]  arg_oh;
    logic [N-1:0]  src_oh;

    assign arg_oh = N'(1) << arg;
    assign src_oh = N'(1) << src;

    always_comb begin
        st_d = st_q;
        if (upd) begin
            for (int s = 0; s < N; s++) begin
                for (int t = 0; t < N; t++) begin
                    if (op == OP_RAISE && src_oh[s] && arg_oh[t])
                        st_d.bits[s*N+t] = 1'b1;
                    if (op == OP_CLEAR && arg_oh[s] && src_oh[t])
                        st_d.bits[s*N+t] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.bits;

    // each target line is the OR of its column
    for (genvar t = 0; t < N; t++) begin : g_col
        logic [N-1:0] col;
        for (genvar s = 0; s < N; s++) begin : g_row
            assign col[s] = st_q.bits[s*N+t];
        end
        assign irq[t] = |col;
    end
endmodule

// File: rtl/icu_rdbk.sv
module icu_rdbk
    import icu_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   gnt,
    input  icu_op_e        op,
    input  logic [IW-1:0]  src,
    input  logic [IW-1:0]  arg,
    input  logic [N*N-1:0] pend,
    output logic [N*N-1:0] rd
);
    logic [N-1:0] val;
    logic [N-1:0] arg_oh;
    logic [N-1:0] src_oh;

    assign arg_oh = N'(1) << arg;
    assign src_oh = N'(1) << src;

    // value for the winning port, computed from the matrix before this edge
    always_comb begin
        val = '0;
        unique case (op)
            OP_STATUS: begin
                for (int s = 0; s < N; s++)
                    for (int t = 0; t < N; t++)
                        if (src_oh[s] && arg_oh[t] && pend[s*N+t]) val[0] = 1'b1;
            end
            OP_SOURCE: begin
                for (int n = 0; n < N; n++)
                    for (int t = 0; t < N; t++)
                        if (src_oh[t] && pend[n*N+t]) val[n] = 1'b1;
            end
            default: val = '0;
        endcase
    end

    for (genvar p = 0; p < N; p++) begin : g_port
        logic [N-1:0] rb_d, rb_q;

        always_comb begin
            rb_d = rb_q;
            if (gnt[p]) rb_d = val;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) rb_q <= '0;
            else        rb_q <= rb_d;
        end

        assign rd[p*N +: N] = rb_q;
    end
endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    cmd_valid,
    input  logic [2*N-1:0]  cmd_op,
    input  logic [IW*N-1:0] cmd_core,
    output logic [N-1:0]    cmd_accept,
    output logic [N*N-1:0]  rd_data,
    output logic [N-1:0]    irq_out
);
    logic [IW-1:0] win;
    logic          any;
    icu_op_e       sel_op;
    logic [IW-1:0] sel_arg;

    icu_arb #(.N(N), .IW(IW)) u_arb (
        .req (cmd_valid),
        .gnt (cmd_accept),
        .win (win),
        .any (any)
    );

    // route the winning port's fields
    always_comb begin
        sel_op  = OP_RAISE;
        sel_arg = '0;
        for (int p = 0; p < N; p++) begin
            if (cmd_accept[p]) begin
                sel_op  = icu_op_e'(cmd_op[2*p +: 2]);
                sel_arg = cmd_core[IW*p +: IW];
            end
        end
    end

    logic [N*N-1:0] pend;

    icu_pend #(.N(N), .IW(IW)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (any),
        .op    (sel_op),
        .src   (win),
        .arg   (sel_arg),
        .pend  (pend),
        .irq   (irq_out)
    );

    icu_rdbk #(.N(N), .IW(IW)) u_rdbk (
        .clk   (clk),
        .rst_n (rst_n),
        .gnt   (cmd_accept),
        .op    (sel_op),
        .src   (win),
        .arg   (sel_arg),
        .pend  (pend),
        .rd    (rd_data)
    );
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    cmd_valid,
    input logic [2*N-1:0]  cmd_op,
    input logic [IW*N-1:0] cmd_core,
    input logic [N-1:0]    cmd_accept,
    input logic [N*N-1:0]  rd_data,
    input logic [N-1:0]    irq_out
);
    logic [N-1:0] raise_to;
    logic [N-1:0] clear_at;

    always_comb begin
        raise_to = '0;
        clear_at = '0;
        for (int p = 0; p < N; p++) begin
            if (cmd_accept[p]) begin
                if (cmd_op[2*p +: 2] == 2'd0)
                    raise_to = raise_to | (N'(1) << cmd_core[IW*p +: IW]);
                if (cmd_op[2*p +: 2] == 2'd1)
                    clear_at[p] = 1'b1;
            end
        end
    end

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_accept));
    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept & ~cmd_valid) == '0);
    assert_port0_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid[0] |-> cmd_accept[0]);

    for (genvar t = 0; t < N; t++) begin : g_line
        assert_line_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[t] && !clear_at[t]) |=> irq_out[t]);
        assert_line_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_out[t] && !raise_to[t]) |=> !irq_out[t]);
        assert_line_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            raise_to[t] |=> irq_out[t]);
    end

    for (genvar p = 0; p < N; p++) begin : g_rb
        assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !cmd_accept[p] |=> $stable(rd_data[p*N +: N]));
    end
endmodule

bind icu_top icu_chk #(.N(N), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_core   (cmd_core),
    .cmd_accept (cmd_accept),
    .rd_data    (rd_data),
    .irq_out    (irq_out)
);

// File: tb/sim_icu_top.sv
`timescale 1ns/1ps
module sim_icu_top;
    localparam int N  = 4;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    cmd_valid = '0;
    logic [2*N-1:0]  cmd_op = '0;
    logic [IW*N-1:0] cmd_core = '0;
    logic [N-1:0]    cmd_accept;
    logic [N*N-1:0]  rd_data;
    logic [N-1:0]    irq_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    icu_top #(.N(N), .IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_core(cmd_core), .cmd_accept(cmd_accept), .rd_data(rd_data),
        .irq_out(irq_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rb(int p);
        return 32'(rd_data[p*N +: N]);
    endfunction

    // issue one command and wait until it is accepted; returns at the negedge after the accepting edge
    task automatic send(int p, logic [1:0] op, int arg);
        @(negedge clk);
        cmd_valid[p] = 1'b1;
        cmd_op[2*p +: 2] = op;
        cmd_core[IW*p +: IW] = IW'(arg);
        forever begin
            #1;
            if (cmd_accept[p]) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        cmd_valid[p] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", 32'(irq_out), 0);
        chk("R1 readback after reset", 32'(rd_data), 0);
    endtask

    task automatic t_merge();
        @(negedge clk);
        cmd_valid[1] = 1'b1; cmd_op[3:2] = 2'd0; cmd_core[3:2] = 2'd0;
        cmd_valid[3] = 1'b1; cmd_op[7:6] = 2'd0; cmd_core[7:6] = 2'd0;
        #1 chk("R2 lower port wins", 32'(cmd_accept), 32'b0010);
        @(negedge clk);
        cmd_valid[1] = 1'b0;
        chk("R3 line after first raise", 32'(irq_out), 32'b0001);
        #1 chk("R2 waiting port taken next", 32'(cmd_accept), 32'b1000);
        @(negedge clk);
        cmd_valid[3] = 1'b0;
        chk("R4 merged single line", 32'(irq_out), 32'b0001);
        send(0, 2'd3, 0);
        chk("R8 source vector two senders", rb(0), 32'b1010);
        send(0, 2'd1, 1);
        chk("R9 clear loads zero", rb(0), 0);
        chk("R6 line held with one sender left", 32'(irq_out), 32'b0001);
        send(0, 2'd3, 0);
        chk("R8 source vector one sender", rb(0), 32'b1000);
        send(0, 2'd1, 3);
        chk("R6 line drops after last clear", 32'(irq_out), 0);
    endtask

    task automatic t_status();
        send(2, 2'd0, 1);
        chk("R3 raise 2 to 1", 32'(irq_out), 32'b0010);
        send(2, 2'd2, 1);
        chk("R7 status pending", rb(2), 32'b0001);
        send(2, 2'd2, 3);
        chk("R7 status not pending", rb(2), 0);
        send(1, 2'd1, 0);
        chk("R5 stray clear keeps line", 32'(irq_out), 32'b0010);
        send(2, 2'd2, 1);
        chk("R5 stray clear keeps other bit", rb(2), 32'b0001);
        send(2, 2'd0, 1);
        send(1, 2'd1, 2);
        chk("R10 double raise cleared once", 32'(irq_out), 0);
    endtask

    task automatic t_hold();
        send(0, 2'd0, 3);
        send(3, 2'd3, 0);
        chk("R8 source single", rb(3), 32'b0001);
        send(1, 2'd0, 3);
        chk("R9 readback holds", rb(3), 32'b0001);
        chk("R4 line still one", 32'(irq_out), 32'b1000);
        send(3, 2'd3, 0);
        chk("R8 source updated", rb(3), 32'b0011);
        send(3, 2'd1, 0);
        send(3, 2'd1, 1);
        chk("R6 all cleared", 32'(irq_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge();
        t_status();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule